// File: doc/BRIEF.md
# Predicated Vector Floating-Point Multiply-Extended Unit

This block multiplies the floating-point elements of a 128-bit vector A by the matching elements of a 128-bit vector B. A per-byte predicate mask decides which elements take part. Every element whose predicate bit is clear keeps its value from A, so the output can be written straight back over A.

The multiply is "extended" in one respect. The product of an infinity and a zero is the finite value 2.0, not a NaN, with the sign taken from the two operand signs. This lets software scale arbitrary vectors without NaNs appearing when a length is infinite or zero.

A 2-bit code selects the element format: half, single or double precision. Code 00 is rejected. On each start strobe the block registers the merged result and pulses done one clock later.

Top module: `vfmulx_unit`

## Requirements
- R1: `result_o` and `done_o` are registered one clock after `start_i` is high. `done_o` is high for exactly that one cycle. `result_o` holds its value until the next start, and reset clears all outputs to zero.
- R2: `size_i` picks the element width as 8 << `size_i`: 01 gives 8 binary16 lanes, 10 gives 4 binary32 lanes and 11 gives 2 binary64 lanes. Lane k occupies bits [k*E +: E] of every vector.
- R3: `size_i` = 00 is illegal. One clock later, `undef_o` pulses together with `done_o` and `result_o` equals A unchanged. `undef_o` stays low for every legal code.
- R4: The predicate bit of lane k is `pred_i[k*E/8]`, which is the bit of the lane's lowest byte. A lane with that bit set receives the product. A lane with that bit clear receives its A element, and all other predicate bits are ignored.
- R5: A product of two normal operands is rounded to nearest, ties to even, with the sign being the XOR of the operand signs.
- R6: Infinity times zero, in either operand order, gives 2.0 (exponent field equal to the bias plus one, fraction zero) with sign equal to the XOR of the operand signs.
- R7: Infinity times a nonzero non-NaN value gives infinity. Zero times a finite value gives zero. In both cases the sign is the XOR of the operand signs.
- R8: A NaN operand is returned with its payload kept and the top fraction bit set. If both operands are NaN, the A operand wins.
- R9: An operand with a zero exponent field counts as zero. A product whose rounded magnitude lies below the smallest normal number becomes a signed zero.
- R10: A product whose rounded exponent exceeds the largest finite exponent becomes a signed infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch one operation |
| size_i | input | 2 | Element size code |
| pred_i | input | 16 | Predicate, one bit per byte |
| vec_a_i | input | 128 | First source, value for inactive lanes |
| vec_b_i | input | 128 | Second source |
| result_o | output | 128 | Merged result |
| done_o | output | 1 | Result valid pulse |
| undef_o | output | 1 | Illegal size code pulse |

## Verification
The bound checker watches the timing contract on every cycle: done follows start, the result holds between starts, the illegal-size flag appears with A passed through, and an all-clear predicate leaves A untouched. On lane 0 in single precision it also checks the infinity-times-zero value, NaN quieting and the treatment of zero-exponent operands. Rounding, overflow, underflow flushing, lane placement in every format and mixed predicates can only be shown by the bench. It compares every operation against a model built on real-number arithmetic, using directed special values and pseudo-random operands in all three formats.

// File: rtl/fmx_pkg.sv
`timescale 1ns/1ps
package fmx_pkg;
    typedef enum logic [1:0] {
        SZ_BAD  = 2'b00,
        SZ_HALF = 2'b01,
        SZ_SNGL = 2'b10,
        SZ_DBL  = 2'b11
    } esize_e;

    localparam int HALF_EW = 5;
    localparam int HALF_FW = 10;
    localparam int SNGL_EW = 8;
    localparam int SNGL_FW = 23;
    localparam int DBL_EW  = 11;
    localparam int DBL_FW  = 52;
endpackage

// File: rtl/fmx_lane.sv
`timescale 1ns/1ps
// One element of the multiply-extended operation, any IEEE binary format.
module fmx_lane #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] a_i,
    input  logic [EW+FW:0] b_i,
    output logic [EW+FW:0] y_o
);
    localparam int PW = 2*FW + 2;
    localparam int XW = EW + 2;
    localparam logic [EW-1:0] EMAX    = {EW{1'b1}};
    localparam logic [EW-1:0] TWO_EXP = {1'b1, {(EW-1){1'b0}}};
    localparam logic [XW-1:0] BIAS    = {3'b000, {(EW-1){1'b1}}};
    localparam logic [FW-1:0] QBIT    = {1'b1, {(FW-1){1'b0}}};

    logic                 sa, sb, sy;
    logic [EW-1:0]        ea, eb;
    logic [FW-1:0]        fa, fb;
    logic                 a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
    logic [PW-1:0]        prod;
    logic [PW-2:0]        norm;
    logic                 guard, sticky, rup;
    logic [FW:0]          rnd;
    logic signed [XW-1:0] ey;

    always_comb begin
        {sa, ea, fa} = a_i;
        {sb, eb, fb} = b_i;
        sy     = sa ^ sb;
        a_nan  = (ea == EMAX) && (fa != '0);
        b_nan  = (eb == EMAX) && (fb != '0);
        a_inf  = (ea == EMAX) && (fa == '0);
        b_inf  = (eb == EMAX) && (fb == '0);
        a_zero = (ea == '0);
        b_zero = (eb == '0);

        // significand product lies in [1,4); move the leading one to the top
        prod   = PW'({1'b1, fa}) * PW'({1'b1, fb});
        norm   = prod[PW-1] ? prod[PW-2:0] : {prod[PW-3:0], 1'b0};
        guard  = norm[FW];
        sticky = |norm[FW-1:0];
        rup    = guard & (sticky | norm[FW+1]);
        rnd    = {1'b0, norm[PW-2:FW+1]} + (FW+1)'(rup);
        ey     = XW'(ea) + XW'(eb) - BIAS + XW'(prod[PW-1]) + XW'(rnd[FW]);

        if (a_nan) begin
            y_o = {sa, ea, fa | QBIT};
        end else if (b_nan) begin
            y_o = {sb, eb, fb | QBIT};
        end else if ((a_inf && b_zero) || (a_zero && b_inf)) begin
            y_o = {sy, TWO_EXP, {FW{1'b0}}};
        end else if (a_inf || b_inf) begin
            y_o = {sy, EMAX, {FW{1'b0}}};
        end else if (a_zero || b_zero) begin
            y_o = {sy, {EW{1'b0}}, {FW{1'b0}}};
        end else if (ey <= 0) begin
            y_o = {sy, {EW{1'b0}}, {FW{1'b0}}};
        end else if (ey >= $signed({2'b00, EMAX})) begin
            y_o = {sy, EMAX, {FW{1'b0}}};
        end else begin
            y_o = {sy, ey[EW-1:0], rnd[FW-1:0]};
        end
    end
endmodule

// File: rtl/fmx_vec.sv
`timescale 1ns/1ps
// All lanes of one element format, merged with the first operand under predicate.
module fmx_vec #(
    parameter int VLEN  = 128,
    parameter int EW    = 8,
    parameter int FW    = 23,
    parameter int LANES = VLEN / (EW + FW + 1)
) (
    input  logic [VLEN-1:0]  a_i,
    input  logic [VLEN-1:0]  b_i,
    input  logic [LANES-1:0] act_i,
    output logic [VLEN-1:0]  y_o
);
    localparam int EL = EW + FW + 1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [EL-1:0] prod_k;
        fmx_lane #(.EW(EW), .FW(FW)) lane_i (
            .a_i (a_i[k*EL +: EL]),
            .b_i (b_i[k*EL +: EL]),
            .y_o (prod_k)
        );
        assign y_o[k*EL +: EL] = act_i[k] ? prod_k : a_i[k*EL +: EL];
    end
endmodule

// File: rtl/vfmulx_unit.sv
`timescale 1ns/1ps
module vfmulx_unit
    import fmx_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [1:0]        size_i,
    input  logic [VLEN/8-1:0] pred_i,
    input  logic [VLEN-1:0]   vec_a_i,
    input  logic [VLEN-1:0]   vec_b_i,
    output logic [VLEN-1:0]   result_o,
    output logic              done_o,
    output logic              undef_o
);
    localparam int PBITS = VLEN / 8;
    localparam int NH    = VLEN / 16;
    localparam int NS    = VLEN / 32;
    localparam int ND    = VLEN / 64;
    localparam logic [PBITS-1:0] ODD_BYTES = {(PBITS/2){2'b10}};

    typedef struct packed {
        logic [VLEN-1:0] res;
        logic            done;
        logic            undef;
    } st_t;

    st_t st_d, st_q;

    logic [NH-1:0]   act_h;
    logic [NS-1:0]   act_s;
    logic [ND-1:0]   act_d;
    logic [VLEN-1:0] y_h, y_s, y_d;
    logic            unused_pred;

    // each lane's predicate is the bit of its lowest byte
    for (genvar k = 0; k < NH; k++) begin : g_ph
        assign act_h[k] = pred_i[2*k];
    end
    for (genvar k = 0; k < NS; k++) begin : g_ps
        assign act_s[k] = pred_i[4*k];
    end
    for (genvar k = 0; k < ND; k++) begin : g_pd
        assign act_d[k] = pred_i[8*k];
    end
    assign unused_pred = ^(pred_i & ODD_BYTES);

    fmx_vec #(.VLEN(VLEN), .EW(HALF_EW), .FW(HALF_FW)) half_i (
        .a_i(vec_a_i), .b_i(vec_b_i), .act_i(act_h), .y_o(y_h));
    fmx_vec #(.VLEN(VLEN), .EW(SNGL_EW), .FW(SNGL_FW)) sngl_i (
        .a_i(vec_a_i), .b_i(vec_b_i), .act_i(act_s), .y_o(y_s));
    fmx_vec #(.VLEN(VLEN), .EW(DBL_EW), .FW(DBL_FW)) dbl_i (
        .a_i(vec_a_i), .b_i(vec_b_i), .act_i(act_d), .y_o(y_d));

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.undef = 1'b0;
        if (start_i) begin
            st_d.done = 1'b1;
            case (esize_e'(size_i))
                SZ_HALF: st_d.res = y_h;
                SZ_SNGL: st_d.res = y_s;
                SZ_DBL:  st_d.res = y_d;
                default: begin
                    st_d.res   = vec_a_i;
                    st_d.undef = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;
    assign done_o   = st_q.done;
    assign undef_o  = st_q.undef;
endmodule

// File: rtl/vfmulx_unit_chk.sv
`timescale 1ns/1ps
module vfmulx_unit_chk #(
    parameter int VLEN = 128
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [1:0]        size_i,
    input logic [VLEN/8-1:0] pred_i,
    input logic [VLEN-1:0]   vec_a_i,
    input logic [VLEN-1:0]   vec_b_i,
    input logic [VLEN-1:0]   result_o,
    input logic              done_o,
    input logic              undef_o
);
    logic s_lane0;
    logic a0_inf, a0_nan, a0_zero, b0_inf, b0_nan, b0_zero;

    assign s_lane0 = start_i && (size_i == 2'b10) && pred_i[0];
    assign a0_inf  = (vec_a_i[30:23] == 8'hFF) && (vec_a_i[22:0] == '0);
    assign a0_nan  = (vec_a_i[30:23] == 8'hFF) && (vec_a_i[22:0] != '0);
    assign a0_zero = (vec_a_i[30:23] == 8'h00);
    assign b0_inf  = (vec_b_i[30:23] == 8'hFF) && (vec_b_i[22:0] == '0);
    assign b0_nan  = (vec_b_i[30:23] == 8'hFF) && (vec_b_i[22:0] != '0);
    assign b0_zero = (vec_b_i[30:23] == 8'h00);

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> done_o); // R1
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> !done_o); // R1
    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> $stable(result_o)); // R1
    AST_BAD_SIZE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && size_i == 2'b00) |=> (undef_o && done_o && result_o == $past(vec_a_i))); // R3
    AST_GOOD_SIZE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && size_i != 2'b00) |=> !undef_o); // R3
    AST_ALL_INACTIVE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && pred_i == '0) |=> (result_o == $past(vec_a_i))); // R4
    AST_INF_ZERO_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_lane0 && ((a0_inf && b0_zero) || (a0_zero && b0_inf)))
        |=> (result_o[30:0] == 31'h4000_0000 &&
             result_o[31] == ($past(vec_a_i[31]) ^ $past(vec_b_i[31])))); // R6
    AST_INF_KEEPS_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_lane0 && a0_inf && !b0_zero && !b0_nan) |=> (result_o[30:0] == 31'h7F80_0000)); // R7
    AST_NAN_QUIETED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_lane0 && a0_nan) |=> (result_o[31:0] == ($past(vec_a_i[31:0]) | 32'h0040_0000))); // R8
    AST_ZERO_EXP_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_lane0 && a0_zero && !b0_nan && !b0_inf) |=> (result_o[30:0] == '0)); // R9
endmodule

bind vfmulx_unit vfmulx_unit_chk #(.VLEN(VLEN)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .size_i   (size_i),
    .pred_i   (pred_i),
    .vec_a_i  (vec_a_i),
    .vec_b_i  (vec_b_i),
    .result_o (result_o),
    .done_o   (done_o),
    .undef_o  (undef_o)
);

// File: tb/vfmulx_unit_tb_top.sv
`timescale 1ns/1ps
module vfmulx_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   size = 2'b00;
    logic [15:0]  pred = '0;
    logic [127:0] va = '0;
    logic [127:0] vb = '0;
    logic [127:0] result;
    logic         done, undef;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    vfmulx_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .pred_i(pred),
        .vec_a_i(va), .vec_b_i(vb), .result_o(result), .done_o(done), .undef_o(undef));

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pk(input bit s, input longint e, input longint f,
                                       input int ew, input int fw);
        return (64'(s) << (ew + fw)) | (64'(e) << fw) | 64'(f);
    endfunction

    // behavioural reference for one element: real arithmetic, explicit rounding
    function automatic logic [63:0] ref_lane(input logic [63:0] a, input logic [63:0] b,
                                             input int ew, input int fw);
        longint emax = (longint'(1) << ew) - 1;
        longint bias = (longint'(1) << (ew - 1)) - 1;
        longint one  = longint'(1) << fw;
        longint ea = longint'((a >> fw) & 64'(emax));
        longint eb = longint'((b >> fw) & 64'(emax));
        longint fa = longint'(a & 64'(one - 1));
        longint fb = longint'(b & 64'(one - 1));
        bit sa = a[ew+fw];
        bit sb = b[ew+fw];
        bit rs = sa ^ sb;
        real pa, pb, p, m, fl, rem;
        longint mi, be;
        int x;
        logic [63:0] bits;
        if (ea == emax && fa != 0) return pk(sa, ea, fa | (one >> 1), ew, fw);
        if (eb == emax && fb != 0) return pk(sb, eb, fb | (one >> 1), ew, fw);
        if ((ea == emax && eb == 0) || (ea == 0 && eb == emax)) return pk(rs, bias + 1, 0, ew, fw);
        if (ea == emax || eb == emax) return pk(rs, emax, 0, ew, fw);
        if (ea == 0 || eb == 0) return pk(rs, 0, 0, ew, fw);
        if (fw == 52) begin
            pa = $bitstoreal({1'b0, a[62:0]});
            pb = $bitstoreal({1'b0, b[62:0]});
            bits = $realtobits(pa * pb);
            if (bits[62:52] == 0) return pk(rs, 0, 0, ew, fw);
            return pk(rs, longint'(bits[62:52]), longint'(bits[51:0]), ew, fw);
        end
        pa = (1.0 + real'(fa) / real'(one)) * $pow(2.0, real'(ea - bias));
        pb = (1.0 + real'(fb) / real'(one)) * $pow(2.0, real'(eb - bias));
        p = pa * pb;
        x = 0;
        while (p >= $pow(2.0, real'(x + 1))) x++;
        while (p < $pow(2.0, real'(x))) x--;
        m = p / $pow(2.0, real'(x)) * real'(one);
        fl = $floor(m);
        mi = longint'(fl);
        rem = m - fl;
        if (rem > 0.5 || (rem == 0.5 && mi[0])) mi++;
        if (mi == 2 * one) begin
            mi = one;
            x++;
        end
        be = longint'(x) + bias;
        if (be >= emax) return pk(rs, emax, 0, ew, fw);
        if (be <= 0) return pk(rs, 0, 0, ew, fw);
        return pk(rs, be, mi - one, ew, fw);
    endfunction

    function automatic logic [127:0] model_vec(input logic [1:0] sz, input logic [15:0] pr,
                                               input logic [127:0] a, input logic [127:0] b);
        int e, ew, fw;
        logic [63:0] m;
        logic [127:0] r;
        if (sz == 2'b00) return a;
        e  = 8 << sz;
        ew = (sz == 2'b01) ? 5 : (sz == 2'b10) ? 8 : 11;
        fw = e - 1 - ew;
        m  = (e == 64) ? '1 : ((64'd1 << e) - 1);
        r  = a;
        for (int k = 0; k < 128 / e; k++) begin
            if (pr[k*e/8]) begin
                r = (r & ~(128'(m) << (k * e))) |
                    (128'(ref_lane(64'(a >> (k * e)) & m, 64'(b >> (k * e)) & m, ew, fw))
                     << (k * e));
            end
        end
        return r;
    endfunction

    task automatic run_op(input logic [1:0] sz, input logic [15:0] pr, input logic [127:0] a,
                          input logic [127:0] b, input string req);
        logic [127:0] exp, held;
        @(negedge clk);
        start = 1'b1; size = sz; pred = pr; va = a; vb = b;
        exp = model_vec(sz, pr, a, b);
        @(negedge clk);
        start = 1'b0;
        va = ~a; vb = ~b;
        chk(done === 1'b1, "R1 done", 128'(done), 128'(1));
        chk(result === exp, req, result, exp);
        chk(undef === (sz == 2'b00), "R3 undef flag", 128'(undef), 128'(sz == 2'b00));
        held = result;
        @(negedge clk);
        chk(done === 1'b0 && result === held, "R1 hold", result, held);
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(result === '0 && done === 1'b0 && undef === 1'b0, "R1 reset",
            {result[125:0], done, undef}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R2: single precision, all lanes active
        run_op(2'b10, 16'hFFFF, {32'h3FC0_0000, 32'hC040_0000, 32'h3DCC_CCCD, 32'h4049_0FDB},
                                {32'h4000_0000, 32'h3DCC_CCCD, 32'hC1A0_0000, 32'h3F35_04F3},
               "R5 single normal");
        // R4: lanes 0 and 2 active through lowest-byte bits
        run_op(2'b10, 16'h0F0F, {32'h3FC0_0000, 32'h4000_0000, 32'h4040_0000, 32'h4080_0000},
                                {32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000},
               "R4 mixed predicate");
        // R4: only non-lowest byte bits set, nothing active
        run_op(2'b10, 16'hEEEE, {32'h3FC0_0000, 32'h4000_0000, 32'h4040_0000, 32'h4080_0000},
                                {32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000},
               "R4 ignored predicate bits");
        // R6: infinity times zero in both orders and signs
        run_op(2'b10, 16'hFFFF, {32'h7F80_0000, 32'h0000_0000, 32'hFF80_0000, 32'h7F80_0000},
                                {32'h0000_0000, 32'hFF80_0000, 32'h0000_0000, 32'h8000_0000},
               "R6 inf times zero");
        // R7: infinity and zero against finite values
        run_op(2'b10, 16'hFFFF, {32'h7F80_0000, 32'hFF80_0000, 32'h0000_0000, 32'h8000_0000},
                                {32'h4040_0000, 32'hFF80_0000, 32'hC0A0_0000, 32'h3F80_0000},
               "R7 inf and zero");
        // R8: NaN quieting and priority
        run_op(2'b10, 16'hFFFF, {32'h7FC0_1234, 32'h7F80_0055, 32'h3F80_0000, 32'hFF80_0777},
                                {32'h3F80_0000, 32'h4000_0000, 32'hFF80_0042, 32'h7FC0_0009},
               "R8 NaN propagation");
        // R9: zero-exponent operands and underflow flush
        run_op(2'b10, 16'hFFFF, {32'h0000_0123, 32'h0080_0000, 32'h8080_0000, 32'h00FF_FFFF},
                                {32'h4000_0000, 32'h3F00_0000, 32'h3F00_0000, 32'h3F00_0000},
               "R9 flush to zero");
        // R10: overflow to signed infinity
        run_op(2'b10, 16'hFFFF, {32'h7F7F_FFFF, 32'hFF7F_FFFF, 32'h7F00_0000, 32'h3F80_0000},
                                {32'h4000_0000, 32'h4000_0000, 32'h7F00_0000, 32'h7F7F_FFFF},
               "R10 overflow");
        // R2: half precision lanes with predicate pattern
        run_op(2'b01, 16'b0101_0001_0100_0101,
               {16'h3C00, 16'h4000, 16'hBE00, 16'h7C00, 16'h7BFF, 16'h7E01, 16'h0001, 16'h3555},
               {16'h4000, 16'h4000, 16'h4000, 16'h0000, 16'h4000, 16'h3C00, 16'h3C00, 16'h3555},
               "R2 half lanes");
        // R2: double precision lanes
        run_op(2'b11, 16'h0101, {64'h3FF8_0000_0000_0000, 64'h7FF0_0000_0000_0000},
                                {64'hC008_0000_0000_0000, 64'h8000_0000_0000_0000},
               "R2 double lanes");
        run_op(2'b11, 16'h0001, {64'h4000_0000_0000_0000, 64'h3FB9_9999_9999_999A},
                                {64'h4000_0000_0000_0000, 64'h3FB9_9999_9999_999A},
               "R2 double lane 0 only");
        // R3: illegal size leaves A
        run_op(2'b00, 16'hFFFF, {4{32'h3FC0_0000}}, {4{32'h4000_0000}}, "R3 illegal size");

        // R5: pseudo-random operands in every format
        for (int s = 1; s < 4; s++) begin
            for (int n = 0; n < 25; n++) begin
                run_op(2'(s), 16'($urandom()),
                       {$urandom(), $urandom(), $urandom(), $urandom()},
                       {$urandom(), $urandom(), $urandom(), $urandom()},
                       "R5 random operands");
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule